// File: doc/BRIEF.md
# Dual-Timebase Programmable Pulse Divider

This block generates a square-ish digital pulse train whose frequency is a chosen timebase divided by a 16-bit ratio. Two timebases are available. The first is a clock enable derived from the system clock by a fixed prescaler: one tick every 16 system cycles, so a 20 MHz system clock gives 1.25 MHz. The second is an independent input clock that runs asynchronously to the system clock (nominally 7.16 MHz), where every cycle of that clock is one tick. A typical use is a 1 kHz probe-compensation signal: the prescaled timebase with a ratio of 1250.

Configuration is written in the system clock domain with a single-cycle write strobe carrying the ratio and the timebase choice. Ratios below 3 are raised to 3. The asynchronous path receives each written configuration through a request/acknowledge handshake. Each period starts with a high phase of floor(ratio/2) ticks, followed by a low phase for the remaining ticks. A changed ratio or timebase takes effect only at the end of the period in progress. A change of timebase lets the old source finish its period and go idle before the new source starts. Dropping the enable input forces the output low and resets the period counters.

Top module: `dual_clock_divider`

## Requirements
- R1: While running, each output period lasts exactly `ratio` ticks of the selected timebase. The output is high for the first floor(ratio/2) ticks and low for the remaining ticks.
- R2: With `wr_src` = 0 (prescaled timebase), one tick occurs every `TICK_DIV` system clock cycles (default 16). A ratio of 1250 therefore gives a period of 20000 system cycles, which is 1 kHz from a 20 MHz clock.
- R3: With `wr_src` = 1 (asynchronous timebase), every rising edge of `alt_clk` is one tick.
- R4: A written ratio of 0, 1 or 2 behaves as 3. Every ratio from 3 up to 65535 is honoured in full.
- R5: A ratio written during a period does not alter that period. The new ratio governs the next period.
- R6: After a timebase change, the old timebase completes its current period with its high phase intact. The new timebase begins only once the old one is idle, so the two never produce overlapping or shortened pulses.
- R7: Configuration reaches the asynchronous domain through a req/ack handshake. When writes arrive faster than the handshake completes, the most recent write is the one that ends up in use.
- R8: While `out_en` is low, `wave_out` stays low and the period counters are held cleared. After `out_en` rises, the first period is full length and begins with its high phase.
- R9: After reset, and until `out_en` is raised, `wave_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the prescaled timebase |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| alt_clk | input | 1 | Independent clock used as the asynchronous timebase |
| out_en | input | 1 | Level enable; when low the output is held low |
| wr_en | input | 1 | Single-cycle strobe that loads `wr_ratio` and `wr_src` |
| wr_ratio | input | 16 | Divide ratio; values below 3 are treated as 3 |
| wr_src | input | 1 | Timebase choice: 0 = prescaled system clock, 1 = `alt_clk` |
| wave_out | output | 1 | Divided pulse train |

## Verification
The bench builds the divider with its default `TICK_DIV` of 16 and two synchronizer stages. As a result, the 1250-ratio case is measured at its true length of 20000 system cycles rather than at a scaled-down stand-in. `alt_clk` runs slightly faster than the 200 MHz system clock (4 ns against 5 ns). This keeps the largest ratio, 65535, to a single period of about 262 µs. Because the two clocks keep drifting against each other, the handshake and the busy exchange between the domains are exercised at varying phase offsets.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  localparam int RATIO_W = 16;

  typedef logic [RATIO_W-1:0] ratio_t;

  localparam ratio_t RATIO_MIN = ratio_t'(3);

  typedef enum logic {
    SRC_SYNC  = 1'b0,
    SRC_ASYNC = 1'b1
  } src_e;

  typedef struct packed {
    ratio_t ratio;
    src_e   src;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Raise any ratio below the legal minimum to that minimum.
  function automatic ratio_t clamp_ratio(input ratio_t r);
    return (r < RATIO_MIN) ? RATIO_MIN : r;
  endfunction

  // Number of ticks spent high in one period.
  function automatic ratio_t high_ticks(input ratio_t r);
    return r >> 1;
  endfunction

endpackage

// File: rtl/fdiv_sync.sv
module fdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/fdiv_prescale.sv
module fdiv_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      logic unused_rst;
      assign unused_rst = rst_n;
      assign tick = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick = (cnt_q == LAST);

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/fdiv_cdc_bus.sv
module fdiv_cdc_bus #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         a_clk,
  input  logic         a_rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         b_clk,
  input  logic         b_rst_n,
  output logic [W-1:0] dout
);

  // Source side
  logic [W-1:0] hold_q;
  logic         req_q, pend_q, ack_s, busy, launch;

  fdiv_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(a_clk), .rst_n(a_rst_n), .d(ack_q), .q(ack_s)
  );

  assign busy   = (req_q != ack_s);
  assign launch = !busy && (load || pend_q);

  always_ff @(posedge a_clk or negedge a_rst_n) begin
    if (!a_rst_n) begin
      hold_q <= '0;
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (launch) begin
      hold_q <= din;
      req_q  <= ~req_q;
      pend_q <= 1'b0;
    end else if (load) begin
      pend_q <= 1'b1;
    end
  end

  // Destination side
  logic         req_s, seen_q, ack_q, take;
  logic [W-1:0] dout_q;

  fdiv_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(b_clk), .rst_n(b_rst_n), .d(req_q), .q(req_s)
  );

  assign take = (req_s != seen_q);

  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      seen_q <= 1'b0;
      dout_q <= '0;
    end else if (take) begin
      seen_q <= req_s;
      dout_q <= hold_q;
    end
  end

  assign ack_q = seen_q;
  assign dout  = dout_q;

  // R7
  hold_stable_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    busy |=> $stable(hold_q));

  // R7
  pend_capture_chk: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    (load && busy) |=> pend_q);

  // R7
  dout_steady_chk: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    !take |=> $stable(dout_q));

endmodule

// File: rtl/fdiv_engine.sv
module fdiv_engine
  import fdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   tick,
  input  logic   run,
  input  logic   hold_off,
  input  ratio_t ratio_in,
  output logic   wave,
  output logic   busy
);

  ratio_t cnt_q, len_q, hi_q, cnt_nx;
  logic   act_q, wave_q;
  logic   at_end, start, reload, advance;

  assign cnt_nx  = cnt_q + 1'b1;
  assign at_end  = act_q && tick && (cnt_q == len_q - 1'b1);
  assign start   = !act_q && tick && run && !hold_off;
  assign reload  = start || (at_end && run);
  assign advance = act_q && tick && !at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= RATIO_MIN;
      hi_q   <= '0;
      wave_q <= 1'b0;
    end else if (clear) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (reload) begin
      act_q  <= 1'b1;
      cnt_q  <= '0;
      len_q  <= ratio_in;
      hi_q   <= high_ticks(ratio_in);
      wave_q <= 1'b1;
    end else if (at_end) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (advance) begin
      cnt_q  <= cnt_nx;
      wave_q <= (cnt_nx < hi_q);
    end
  end

  assign wave = wave_q;
  assign busy = act_q;

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < len_q));

  // R1
  wave_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_q |-> act_q);

  // R4
  min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (len_q >= RATIO_MIN));

  // R5
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !at_end && !clear) |=> $stable(len_q));

  // R8
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!wave_q && !act_q && cnt_q == '0));

  // R6
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(!hold_off));

endmodule

// File: rtl/dual_clock_divider.sv
module dual_clock_divider
  import fdiv_pkg::*;
#(
  parameter int TICK_DIV    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alt_clk,
  input  logic               out_en,
  input  logic               wr_en,
  input  logic [RATIO_W-1:0] wr_ratio,
  input  logic               wr_src,
  output logic               wave_out
);

  // R9: both domains come out of reset idle and low.
  logic [1:0] arst_q;
  logic       arst_n;

  always_ff @(posedge alt_clk or negedge rst_n) begin
    if (!rst_n) arst_q <= 2'b00;
    else        arst_q <= {arst_q[0], 1'b1};
  end
  assign arst_n = arst_q[1];

  // System-domain configuration (R4 clamp applied on write)
  cfg_t cfg_q;
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{ratio: RATIO_MIN, src: SRC_SYNC};
      wr_q  <= 1'b0;
    end else begin
      wr_q <= wr_en;
      if (wr_en) begin
        cfg_q.ratio <= clamp_ratio(wr_ratio);
        cfg_q.src   <= src_e'(wr_src);
      end
    end
  end

  // R7: configuration handed to the asynchronous domain
  logic [CFG_W-1:0] alt_cfg_bits;
  cfg_t             alt_cfg;

  fdiv_cdc_bus #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_cdc (
    .a_clk   (clk),
    .a_rst_n (rst_n),
    .load    (wr_q),
    .din     (cfg_q),
    .b_clk   (alt_clk),
    .b_rst_n (arst_n),
    .dout    (alt_cfg_bits)
  );
  assign alt_cfg = cfg_t'(alt_cfg_bits);

  // Cross-domain status
  logic alt_en, sys_busy, alt_busy, sys_busy_a, alt_busy_s;

  fdiv_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(alt_clk), .rst_n(arst_n), .d(out_en), .q(alt_en)
  );
  fdiv_sync #(.STAGES(SYNC_STAGES)) u_sbusy_sync (
    .clk(alt_clk), .rst_n(arst_n), .d(sys_busy), .q(sys_busy_a)
  );
  fdiv_sync #(.STAGES(SYNC_STAGES)) u_abusy_sync (
    .clk(clk), .rst_n(rst_n), .d(alt_busy), .q(alt_busy_s)
  );

  // Prescaled timebase (R2)
  logic sys_tick;

  fdiv_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(sys_tick)
  );

  // Engines
  logic sys_run, alt_run, sys_wave, alt_wave;

  assign sys_run = out_en && (cfg_q.src == SRC_SYNC);
  assign alt_run = alt_en && (alt_cfg.src == SRC_ASYNC);

  fdiv_engine u_sys_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!out_en),
    .tick     (sys_tick),
    .run      (sys_run),
    .hold_off (alt_busy_s),
    .ratio_in (cfg_q.ratio),
    .wave     (sys_wave),
    .busy     (sys_busy)
  );

  // R3: every alt_clk edge is a tick
  fdiv_engine u_alt_eng (
    .clk      (alt_clk),
    .rst_n    (arst_n),
    .clear    (!alt_en),
    .tick     (1'b1),
    .run      (alt_run),
    .hold_off (sys_busy_a),
    .ratio_in (alt_cfg.ratio),
    .wave     (alt_wave),
    .busy     (alt_busy)
  );

  assign wave_out = sys_wave | alt_wave;

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_wave |-> !alt_busy_s);

  // R4
  cfg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q.ratio >= RATIO_MIN));

  // R8
  sys_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !sys_wave);

endmodule

// File: tb/dual_clock_divider_tb.sv
`timescale 1ns/1ps
module dual_clock_divider_tb;

  localparam int  TDIV   = 16;
  localparam real CLK_NS = 5.0;
  localparam real ALT_NS = 4.0;
  localparam real SYS_TICK_NS = TDIV * CLK_NS;

  logic        clk = 1'b0;
  logic        alt_clk = 1'b0;
  logic        rst_n;
  logic        out_en;
  logic        wr_en;
  logic [15:0] wr_ratio;
  logic        wr_src;
  logic        wave_out;

  always #2.5 clk = ~clk;
  always #2.0 alt_clk = ~alt_clk;

  dual_clock_divider #(.TICK_DIV(TDIV), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk), .out_en(out_en),
    .wr_en(wr_en), .wr_ratio(wr_ratio), .wr_src(wr_src), .wave_out(wave_out)
  );

  int n_vec = 0;
  int n_bad = 0;

  typedef struct {
    real   hi;
    real   lo;
    bit    lo_min;
    string tag;
  } item_t;

  item_t exp_q[$];

  function automatic int eff_ratio(input int r);
    return (r < 3) ? 3 : r;
  endfunction

  function automatic bit near(input real a, input real b);
    return (a - b < 0.5) && (b - a < 0.5);
  endfunction

  // Driver side: push expected periods
  task automatic push_period(input int r, input real tick_ns, input bit lo_min, input string tag);
    item_t it;
    int e;
    e = eff_ratio(r);
    it.hi = (e / 2) * tick_ns;
    it.lo = (e - e / 2) * tick_ns;
    it.lo_min = lo_min;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  task automatic write_cfg(input int r, input bit src);
    @(negedge clk);
    wr_en = 1'b1; wr_ratio = 16'(r); wr_src = src;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(posedge clk);
    @(posedge wave_out);
    #1;
  endtask

  task automatic expect_steady(input int n, input int r, input real tick_ns, input string tag);
    for (int i = 0; i < n; i++) push_period(r, tick_ns, 1'b0, tag);
    drain();
  endtask

  task automatic check_low(input int cycles, input string tag);
    int highs;
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wave_out !== 1'b0) highs++;
    end
    n_vec++;
    if (highs != 0) begin
      n_bad++;
      $display("FAIL %s: wave_out high in %0d sampled cycles, expected 0", tag, highs);
    end
  endtask

  // Monitor: measures each completed period and compares with the queue
  initial begin : monitor
    real t_rise, t_fall, hi_m, lo_m;
    bit  have_r, have_f, ok;
    item_t it;
    t_rise = 0.0; t_fall = 0.0; have_r = 1'b0; have_f = 1'b0;
    forever begin
      @(wave_out);
      if (wave_out === 1'b1) begin
        if (have_r && have_f && exp_q.size() > 0) begin
          it   = exp_q.pop_front();
          hi_m = t_fall - t_rise;
          lo_m = $realtime - t_fall;
          ok   = near(hi_m, it.hi) && (it.lo_min ? (lo_m > it.lo - 0.5) : near(lo_m, it.lo));
          n_vec++;
          if (!ok) begin
            n_bad++;
            $display("FAIL %s: high %0.1f ns low %0.1f ns, expected high %0.1f low %0s%0.1f ns",
                     it.tag, hi_m, lo_m, it.hi, it.lo_min ? ">=" : "", it.lo);
          end
        end
        t_rise = $realtime; have_r = 1'b1; have_f = 1'b0;
      end else begin
        t_fall = $realtime; have_f = have_r;
      end
    end
  end

  // Watchdog
  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R1: run timed out, got no completion, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b1; out_en = 1'b0; wr_en = 1'b0; wr_ratio = '0; wr_src = 1'b0;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R9: low during reset
    n_vec++;
    if (wave_out !== 1'b0) begin
      n_bad++; $display("FAIL R9: wave_out=%b in reset, expected 0", wave_out);
    end
    rst_n = 1'b1;
    check_low(100, "R9");

    // R8 first period after enable is full; R1 odd ratio on prescaled timebase
    write_cfg(7, 1'b0);
    out_en = 1'b1;
    @(posedge wave_out); #1;
    push_period(7, SYS_TICK_NS, 1'b0, "R8");
    expect_steady(2, 7, SYS_TICK_NS, "R1");

    // R1 even ratio
    write_cfg(8, 1'b0); settle();
    expect_steady(2, 8, SYS_TICK_NS, "R1");

    // R4 clamp of small ratios
    write_cfg(1, 1'b0); settle();
    expect_steady(2, 1, SYS_TICK_NS, "R4");
    write_cfg(0, 1'b0); settle();
    expect_steady(1, 0, SYS_TICK_NS, "R4");
    write_cfg(2, 1'b0); settle();
    expect_steady(1, 2, SYS_TICK_NS, "R4");

    // R5 change mid-period
    write_cfg(8, 1'b0); settle();
    @(posedge wave_out); #1;
    push_period(8, SYS_TICK_NS, 1'b0, "R5");
    push_period(12, SYS_TICK_NS, 1'b0, "R5");
    write_cfg(12, 1'b0);
    drain();

    // R2 1250 ratio: 20000 system cycles
    write_cfg(1250, 1'b0); settle();
    expect_steady(1, 1250, SYS_TICK_NS, "R2");

    // R8 disable holds low
    out_en = 1'b0;
    @(negedge clk);
    check_low(200, "R8");
    write_cfg(6, 1'b0);
    out_en = 1'b1;
    settle();
    expect_steady(1, 6, SYS_TICK_NS, "R1");

    // R6 switch prescaled -> asynchronous
    @(posedge wave_out); #1;
    push_period(6, SYS_TICK_NS, 1'b1, "R6");
    write_cfg(5, 1'b1);
    drain();
    settle();
    expect_steady(3, 5, ALT_NS, "R3");

    // R7 back-to-back writes: last one wins
    @(negedge clk);
    wr_en = 1'b1; wr_ratio = 16'd9; wr_src = 1'b1;
    @(negedge clk);
    wr_ratio = 16'd11;
    @(negedge clk);
    wr_en = 1'b0;
    settle();
    expect_steady(2, 11, ALT_NS, "R7");

    // R8 disable on asynchronous timebase, then full first period
    out_en = 1'b0;
    repeat (10) @(negedge clk);
    check_low(100, "R8");
    out_en = 1'b1;
    @(posedge wave_out); #1;
    push_period(11, ALT_NS, 1'b0, "R8");
    drain();

    // R6 switch asynchronous -> prescaled
    @(posedge wave_out); #1;
    push_period(11, ALT_NS, 1'b1, "R6");
    write_cfg(4, 1'b0);
    drain();
    settle();
    expect_steady(2, 4, SYS_TICK_NS, "R2");

    // R4 largest ratio on asynchronous timebase
    write_cfg(65535, 1'b1); settle();
    expect_steady(1, 65535, ALT_NS, "R4");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule